// File: doc/BRIEF.md
# Load Latency Threshold Event Monitor

This block watches load operations in a processor pipeline and measures how many core clock cycles each one takes. A load is timed from the first time it is dispatched until its data is written back. Each in-flight load is named by a small tag, and every tag has its own latency timer. A load that is dispatched again while already in flight keeps its original start time, so the measured figure includes all the time spent on re-dispatch.

When a load has both retired and written back, the monitor evaluates it. It counts the load only under all of these conditions:
- the load is a demand load;
- the monitor is enabled and programmed with the right event code;
- the measured latency is strictly above a programmable threshold.

For each counted load, the monitor also latches the latency and pulses a sample-valid output, so that a separate sampling unit can build a record. A load cancelled before retirement frees its tag and leaves the count untouched. The event counter wraps to zero and flags each wrap with a one-cycle pulse.

Top module: `llmon_top`

## Requirements
- R1: The latency of a load equals the number of rising clock edges from the edge that samples its first dispatch to the edge that samples its writeback; this value appears on `sampleLatency` for a counted load.
- R2: A dispatch on a tag that is already in flight is a re-dispatch: it neither restarts the timer nor changes the demand flag.
- R3: The latency timer saturates at 2^TMR_W-1 and does not wrap.
- R4: Only demand loads (`dispDemand`=1 at first dispatch) that retire are counted; non-demand loads never change `count`.
- R5: Counting happens only when `cfgEnable`=1 and `cfgEvent`==16'h01CD (bits [7:0] = event select CDh, bits [15:8] = unit mask 01h); otherwise `count` holds.
- R6: A load counts only when its latency is strictly greater than `cfgThreshold`; equal does not count.
- R7: `count` increments by one per counted load and wraps from all ones to zero; `wrapPulse` is high for exactly the cycle following the wrapping edge.
- R8: On the edge that counts a load, `sampleLatency` takes that load's latency and `sampleValid` is high for the following cycle only.
- R9: A load is evaluated on the edge after the later of its retire and writeback edges; a retire that arrives before writeback is held until writeback.
- R10: A cancel frees the tag without counting; later writeback or retire events on a free tag are ignored, and the tag can be dispatched afresh.
- R11: After reset, `count`, `sampleValid`, `wrapPulse` and `sampleLatency` are zero.
- R12: Loads on different tags are timed independently while in flight together; if several become ready at once, they are evaluated one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | Dispatch event (first or repeated) |
| dispTag | input | 3 | Tag of the dispatched load |
| dispDemand | input | 1 | Load is a demand load (taken on first dispatch) |
| wbValid | input | 1 | Final data writeback event |
| wbTag | input | 3 | Tag of the written-back load |
| retValid | input | 1 | Retirement event |
| retTag | input | 3 | Tag of the retired load |
| cancelValid | input | 1 | Cancel event for a load that will not retire |
| cancelTag | input | 3 | Tag of the cancelled load |
| cfgEvent | input | 16 | Event code: [7:0] select, [15:8] unit mask |
| cfgEnable | input | 1 | Counting enable |
| cfgThreshold | input | TMR_W | Latency threshold (strictly-above compare) |
| count | output | CNT_W | Qualifying-load counter |
| wrapPulse | output | 1 | One-cycle pulse after the counter wraps |
| sampleValid | output | 1 | One-cycle pulse for a counted load |
| sampleLatency | output | TMR_W | Latency of the last counted load |

## Verification
The hardest case to reach is several loads becoming ready close together while their timers overlap, each with a different retire order relative to its writeback. The bench drives a schedule that:
- dispatches all eight tags on consecutive cycles;
- retires every tag early;
- staggers the writebacks, so that each held retirement is released one at a time.

It then checks the number and the sum of the sampled latencies against arithmetic totals. A narrow timer and a narrow counter are used, so that saturation and counter wrap are reached within a short sweep over latency, retire order and a threshold one below, equal to and one above each latency.

// File: rtl/llmon_pkg.sv
`timescale 1ns/1ps
package llmon_pkg;
  parameter int unsigned TAGS = 8;
  localparam int unsigned TAG_W = $clog2(TAGS);
  localparam logic [15:0] EVENT_CODE = 16'h01CD;

  typedef struct packed {
    logic [TAGS-1:0]  start;
    logic [TAGS-1:0]  stop;
    logic             evalGo;
    logic [TAG_W-1:0] evalTag;
    logic             evalQual;
  } llmStrobe_t;
endpackage

// File: rtl/llmon_ctrl.sv
`timescale 1ns/1ps
module llmon_ctrl
  import llmon_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [TAG_W-1:0] dispTag,
  input  logic             dispDemand,
  input  logic             wbValid,
  input  logic [TAG_W-1:0] wbTag,
  input  logic             retValid,
  input  logic [TAG_W-1:0] retTag,
  input  logic             cancelValid,
  input  logic [TAG_W-1:0] cancelTag,
  input  logic [15:0]      cfgEvent,
  input  logic             cfgEnable,
  output llmStrobe_t       strobe
);
  logic [TAGS-1:0] busy, isDemand, wbSeen, retSeen;
  logic [TAGS-1:0] dispHit, wbHit, retHit, cancelHit;
  logic [TAGS-1:0] readyVec, grantVec;
  logic [TAG_W-1:0] pickTag;
  logic found;

  // one-hot decode of the event stream
  always_comb begin
    dispHit   = '0;
    wbHit     = '0;
    retHit    = '0;
    cancelHit = '0;
    if (dispValid)   dispHit[dispTag]     = 1'b1;
    if (wbValid)     wbHit[wbTag]         = 1'b1;
    if (retValid)    retHit[retTag]       = 1'b1;
    if (cancelValid) cancelHit[cancelTag] = 1'b1;
  end

  // a slot is ready once it has both retired and written back
  assign readyVec = busy & wbSeen & retSeen & ~cancelHit;

  // lowest ready tag is evaluated first
  always_comb begin
    grantVec = '0;
    pickTag  = '0;
    found    = 1'b0;
    for (int i = 0; i < TAGS; i++) begin
      if (readyVec[i] && !found) begin
        grantVec[i] = 1'b1;
        pickTag     = TAG_W'(i);
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.start    = dispHit & ~busy & ~cancelHit;
    strobe.stop     = (wbHit & busy & ~wbSeen) | (cancelHit & busy);
    strobe.evalGo   = found;
    strobe.evalTag  = pickTag;
    strobe.evalQual = isDemand[pickTag] & cfgEnable & (cfgEvent == EVENT_CODE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= '0;
      isDemand <= '0;
      wbSeen   <= '0;
      retSeen  <= '0;
    end else begin
      for (int t = 0; t < TAGS; t++) begin
        if (cancelHit[t] || grantVec[t]) begin
          busy[t]     <= 1'b0;
          isDemand[t] <= 1'b0;
          wbSeen[t]   <= 1'b0;
          retSeen[t]  <= 1'b0;
        end else if (strobe.start[t]) begin
          busy[t]     <= 1'b1;
          isDemand[t] <= dispDemand;
          wbSeen[t]   <= 1'b0;
          retSeen[t]  <= 1'b0;
        end else if (busy[t]) begin
          if (wbHit[t])  wbSeen[t]  <= 1'b1;
          if (retHit[t]) retSeen[t] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/llmon_datapath.sv
`timescale 1ns/1ps
module llmon_datapath
  import llmon_pkg::*;
#(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  llmStrobe_t       strobe,
  input  logic [TMR_W-1:0] cfgThreshold,
  output logic [CNT_W-1:0] count,
  output logic             wrapPulse,
  output logic             sampleValid,
  output logic [TMR_W-1:0] sampleLatency
);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [TMR_W-1:0] tmr [TAGS];
  logic [TMR_W-1:0] evalLat;
  logic hit;

  for (genvar t = 0; t < TAGS; t++) begin : g_tmr
    logic [TMR_W-1:0] val;
    logic             on;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        val <= '0;
        on  <= 1'b0;
      end else if (strobe.start[t]) begin
        val <= '0;
        on  <= 1'b1;
      end else begin
        if (on && val != TMR_MAX) val <= val + 1'b1;
        if (strobe.stop[t])       on  <= 1'b0;
      end
    end
    assign tmr[t] = val;
  end

  assign evalLat = tmr[strobe.evalTag];
  assign hit     = strobe.evalGo & strobe.evalQual & (evalLat > cfgThreshold);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count         <= '0;
      wrapPulse     <= 1'b0;
      sampleValid   <= 1'b0;
      sampleLatency <= '0;
    end else begin
      sampleValid <= hit;
      wrapPulse   <= hit && (count == CNT_MAX);
      if (hit) begin
        count         <= count + 1'b1;
        sampleLatency <= evalLat;
      end
    end
  end
endmodule

// File: rtl/llmon_top.sv
`timescale 1ns/1ps
module llmon_top
  import llmon_pkg::*;
#(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [2:0]       dispTag,
  input  logic             dispDemand,
  input  logic             wbValid,
  input  logic [2:0]       wbTag,
  input  logic             retValid,
  input  logic [2:0]       retTag,
  input  logic             cancelValid,
  input  logic [2:0]       cancelTag,
  input  logic [15:0]      cfgEvent,
  input  logic             cfgEnable,
  input  logic [TMR_W-1:0] cfgThreshold,
  output logic [CNT_W-1:0] count,
  output logic             wrapPulse,
  output logic             sampleValid,
  output logic [TMR_W-1:0] sampleLatency
);
  llmStrobe_t strobe;

  llmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispTag(dispTag), .dispDemand(dispDemand),
    .wbValid(wbValid), .wbTag(wbTag),
    .retValid(retValid), .retTag(retTag),
    .cancelValid(cancelValid), .cancelTag(cancelTag),
    .cfgEvent(cfgEvent), .cfgEnable(cfgEnable),
    .strobe(strobe)
  );

  llmon_datapath #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgThreshold(cfgThreshold),
    .count(count), .wrapPulse(wrapPulse),
    .sampleValid(sampleValid), .sampleLatency(sampleLatency)
  );
endmodule

// File: rtl/llmon_chk.sv
`timescale 1ns/1ps
module llmon_chk #(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned CNT_W = 48
) (
  input logic             clk,
  input logic             rstN,
  input logic [15:0]      cfgEvent,
  input logic             cfgEnable,
  input logic [TMR_W-1:0] cfgThreshold,
  input logic [CNT_W-1:0] count,
  input logic             wrapPulse,
  input logic             sampleValid,
  input logic [TMR_W-1:0] sampleLatency
);
  localparam logic [CNT_W-1:0] ONE = 1;

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == CNT_W'($past(count) + ONE)));

  // R8
  sample_marks_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (count != $past(count)));

  // R8
  count_marks_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> sampleValid);

  // R6
  above_threshold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleLatency > $past(cfgThreshold)));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> (count == '0 && sampleValid));

  // R5
  config_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgEnable) || $past(cfgEvent) != 16'h01CD) |-> $stable(count));
endmodule

bind llmon_top llmon_chk #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgEvent(cfgEvent), .cfgEnable(cfgEnable),
  .cfgThreshold(cfgThreshold), .count(count), .wrapPulse(wrapPulse),
  .sampleValid(sampleValid), .sampleLatency(sampleLatency)
);

// File: tb/llmon_top_test.sv
`timescale 1ns/1ps
module llmon_top_test;
  localparam int TW = 6;
  localparam int CW = 4;
  localparam int TMAX = (1 << TW) - 1;
  localparam int CMOD = 1 << CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 0, dispDemand = 0, wbValid = 0, retValid = 0, cancelValid = 0;
  logic [2:0] dispTag = 0, wbTag = 0, retTag = 0, cancelTag = 0;
  logic [15:0] cfgEvent = 16'h01CD;
  logic cfgEnable = 1'b1;
  logic [TW-1:0] cfgThreshold = '0;
  logic [CW-1:0] count;
  logic wrapPulse, sampleValid;
  logic [TW-1:0] sampleLatency;

  int checks = 0, errors = 0, expCount = 0;
  int svSeen = 0, svSum = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  llmon_top #(.TMR_W(TW), .CNT_W(CW)) uut (.*);

  always @(negedge clk) if (rstN && sampleValid) begin
    svSeen++;
    svSum += int'(sampleLatency);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic bit cfgOk();
    return cfgEnable && cfgEvent == 16'h01CD;
  endfunction

  // dispatch at this negedge, writeback lat edges later; retire early or late
  task automatic runLoad(input int tag, input bit dem, input int lat, input bit early, input int thr);
    int elapsed, eff;
    bit hit;
    cfgThreshold = TW'(thr);
    dispValid = 1; dispTag = 3'(tag); dispDemand = dem;
    step(); dispValid = 0;
    elapsed = 1;
    if (early) begin
      retValid = 1; retTag = 3'(tag); step(); retValid = 0; elapsed = 2;
    end
    repeat (lat - elapsed) step();
    wbValid = 1; wbTag = 3'(tag); step(); wbValid = 0;
    if (!early) begin
      retValid = 1; retTag = 3'(tag); step(); retValid = 0;
    end
    step();
    eff = (lat > TMAX) ? TMAX : lat;
    hit = dem && cfgOk() && (eff > thr);
    chk(sampleValid == hit, "R9 R6 R4 sampleValid", sampleValid, hit);
    if (hit) expCount = (expCount + 1) % CMOD;
    chk(int'(count) == expCount, "R7 count", count, expCount);
    chk(wrapPulse == (hit && expCount == 0), "R7 wrapPulse", wrapPulse, hit && expCount == 0);
    if (hit) chk(int'(sampleLatency) == eff, "R1 R3 sampleLatency", sampleLatency, eff);
    step();
    chk(sampleValid == 0, "R8 one-cycle sampleValid", sampleValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, s0;
    repeat (3) step();
    // R11 reset state
    chk(count == 0, "R11 count", count, 0);
    chk(sampleValid == 0, "R11 sampleValid", sampleValid, 0);
    chk(wrapPulse == 0, "R11 wrapPulse", wrapPulse, 0);
    chk(sampleLatency == 0, "R11 sampleLatency", sampleLatency, 0);
    rstN = 1'b1;
    step();

    // R1 R6 R7 R8 R9 sweep: latency, retire order, threshold around latency
    for (int lat = 2; lat <= 12; lat++)
      for (int e = 0; e < 2; e++)
        for (int d = -1; d <= 1; d++)
          runLoad(lat % 8, 1'b1, lat, e[0], lat + d);

    // R4 non-demand loads never count
    runLoad(3, 1'b0, 10, 1'b0, 2);
    runLoad(4, 1'b0, 7, 1'b1, 1);

    // R5 wrong code or disabled
    cfgEnable = 1'b0;     runLoad(1, 1'b1, 9, 1'b0, 2);
    cfgEnable = 1'b1; cfgEvent = 16'h01CC; runLoad(1, 1'b1, 9, 1'b0, 2);
    cfgEvent = 16'h02CD;  runLoad(2, 1'b1, 9, 1'b1, 2);
    cfgEvent = 16'h01CD;  runLoad(2, 1'b1, 9, 1'b1, 2);

    // R3 saturation
    runLoad(6, 1'b1, 70, 1'b0, TMAX - 1);
    runLoad(6, 1'b1, 70, 1'b1, TMAX);

    // R2 re-dispatch does not restart or change demand flag
    cfgThreshold = 1;
    dispValid = 1; dispTag = 2; dispDemand = 1; step(); dispValid = 0;
    step();
    dispValid = 1; dispTag = 2; dispDemand = 0; step(); dispValid = 0;
    repeat (6) step();
    wbValid = 1; wbTag = 2; step(); wbValid = 0;
    retValid = 1; retTag = 2; step(); retValid = 0;
    step();
    chk(sampleValid == 1, "R2 redispatch counted", sampleValid, 1);
    chk(int'(sampleLatency) == 9, "R2 redispatch latency", sampleLatency, 9);
    expCount = (expCount + 1) % CMOD;
    chk(int'(count) == expCount, "R2 count", count, expCount);
    step();

    // R10 cancel frees slot; events on a free tag are ignored
    c0 = svSeen;
    dispValid = 1; dispTag = 5; dispDemand = 1; step(); dispValid = 0;
    repeat (3) step();
    cancelValid = 1; cancelTag = 5; step(); cancelValid = 0;
    wbValid = 1; wbTag = 5; step(); wbValid = 0;
    retValid = 1; retTag = 5; step(); retValid = 0;
    retValid = 1; retTag = 7; step(); retValid = 0;
    repeat (3) step();
    chk(svSeen == c0, "R10 no sample after cancel", svSeen, c0);
    chk(int'(count) == expCount, "R10 count unchanged", count, expCount);
    runLoad(5, 1'b1, 4, 1'b0, 1);

    // R12 eight overlapping loads, early retires, staggered writebacks
    cfgThreshold = 22;
    c0 = svSeen; s0 = svSum;
    for (int c = 0; c < 46; c++) begin
      dispValid = (c < 8); dispTag = 3'(c); dispDemand = 1;
      retValid = (c >= 8 && c < 16); retTag = 3'(c - 8);
      wbValid = (c >= 20 && c < 36 && ((c - 20) % 2 == 0)); wbTag = 3'((c - 20) / 2);
      step();
    end
    dispValid = 0; retValid = 0; wbValid = 0;
    chk(svSeen - c0 == 5, "R12 counted loads", svSeen - c0, 5);
    chk(svSum - s0 == 125, "R12 latency sum", svSum - s0, 125);
    expCount = (expCount + 5) % CMOD;
    chk(int'(count) == expCount, "R12 count", count, expCount);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule